// File: doc/BRIEF.md
# Bit-Parallel NFA Pattern Matcher

This block scans a byte stream, one byte per clock, for a pattern that has been compiled offline into a nondeterministic automaton with one flip-flop per state. Any number of states may be active together. A single lookup memory, addressed by the incoming byte, returns one detection bit per state, so every state learns in the same cycle whether the current byte may carry it forward. Each state is a small matching element. It takes a detection bit, a "predecessor active" input and an epsilon input. It drives its registered state and an epsilon output that reports "this state, or any state reaching it by epsilon, is active".

The automaton shape is fixed by parameters: a predecessor map (character-consuming edges), a forward-only epsilon map and an accept mask. The lookup memory contents are loaded at run time through a write port, which sets the character classes for each state, including any-character classes. State 0 is the start state and is always active, so a match may begin at any byte offset. The default parameters encode the pattern abc(ab)*a. Repetition, optional, one-or-more, grouping and alternation all map onto these same edge maps.

A registered match pulse follows every byte that lands the automaton in an accepting state. A saturating counter totals the pulses. A synchronous clear returns the automaton to its start condition.

Top module: `nfa_regex_top`

## Requirements
- R1: State 0 reads as 1 at all times, including during reset. A match can therefore start at any byte offset of the stream.
- R2: On a clock edge with in_valid_i=1 and clr_i=0, state t (t>=1) becomes 1 exactly when two conditions hold. First, bit t of the lookup word for in_byte_i is 1. Second, some state s with PRED_MAP bit t*N_ST+s set is reachable, meaning s is active or is reached by epsilon edges. EPS_MAP bit t*N_ST+s marks an epsilon edge from s to t, and bits with s>=t are ignored.
- R3: With in_valid_i=0 and clr_i=0, state_o and match_cnt_o keep their values and match_o is 0 in the next cycle.
- R4: match_o is 1 in the cycle after an accepted byte when the new state vector has a state t>=1 set whose ACC_MASK bit is 1. Otherwise match_o is 0.
- R5: match_cnt_o increases by one in each cycle where match_o is 1, and it saturates at 2^CNT_W-1.
- R6: clr_i=1 clears states 1..N_ST-1, match_o and match_cnt_o at the next edge, and it takes priority over in_valid_i.
- R7: lut_we_i=1 writes lut_data_i into entry lut_addr_i at the clock edge. A byte presented in the same cycle is evaluated against the word held before the write. Bit 0 of each word has no effect.
- R8: While rst_ni is low, state_o reads 1 (only the start state), match_o is 0 and match_cnt_o is 0. Release takes effect after two clock edges.
- R9: With the default maps, and with lookup words 'a'(8'h61)=bits 1,4,6, 'b'(8'h62)=bits 2,5, 'c'(8'h63)=bit 3, the input "abca" steps state_o through 7'h03, 7'h05, 7'h09, 7'h53 and raises match_o after the final 'a'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | The byte on in_byte_i is consumed this cycle |
| in_byte_i | input | SYM_W | Input byte |
| clr_i | input | 1 | Synchronous clear of the automaton and counter |
| lut_we_i | input | 1 | Lookup memory write enable |
| lut_addr_i | input | SYM_W | Lookup memory write address (byte value) |
| lut_data_i | input | N_ST | Detection bits per state for that byte |
| state_o | output | N_ST | Registered state vector, bit 0 is the start state |
| match_o | output | 1 | Registered match pulse |
| match_cnt_o | output | CNT_W | Saturating match count |

## Verification
The bench builds the block with the default seven-state maps for abc(ab)*a, the epsilon edge from state 3 to state 5, and CNT_W=3. The short counter lets a run of ten matches drive the count into saturation. The epsilon edge is the only path into the (ab)* loop and to the accepting state, so any error in epsilon handling shows up directly. Reloading the lookup memory mid-run gives an any-character class on one state, and a write to the entry of the byte being consumed in the same cycle exposes which word the read returns.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  // Flat bit position of the edge from state src into state tgt in an n-state map
  function automatic int edge_pos(input int tgt, input int src, input int n);
    return tgt * n + src;
  endfunction
endpackage

// File: rtl/nfa_rst_sync.sv
module nfa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/nfa_class_mem.sv
module nfa_class_mem #(
  parameter int SYM_W = 8,
  parameter int WORD_W = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SYM_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [SYM_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << SYM_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nfa_match_elem.sv
module nfa_match_elem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  input  logic c_i,
  input  logic i_i,
  input  logic ei_i,
  output logic o_o,
  output logic eo_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (clr_i)      q_d = 1'b0;
    else if (adv_i) q_d = c_i & i_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign o_o  = q_q;
  assign eo_o = q_q | ei_i;
endmodule

// File: rtl/nfa_match_cnt.sv
module nfa_match_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic             match_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             match_d, match_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  assign cnt_en = hit_i && (cnt_q != CNT_MAX);

  always_comb begin
    match_d = hit_i;
    cnt_d   = cnt_q;
    if (clr_i) begin
      match_d = 1'b0;
      cnt_d   = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      match_q <= match_d;
      cnt_q   <= cnt_d;
    end
  end

  assign match_o = match_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/nfa_regex_top.sv
module nfa_regex_top #(
  parameter int N_ST = 7,
  parameter int SYM_W = 8,
  parameter int CNT_W = 16,
  parameter logic [N_ST*N_ST-1:0] PRED_MAP = 49'h8082_0080_8080,
  parameter logic [N_ST*N_ST-1:0] EPS_MAP  = 49'h0040_0000_0000,
  parameter logic [N_ST-1:0]      ACC_MASK = 7'b100_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SYM_W-1:0] in_byte_i,
  input  logic             clr_i,
  input  logic             lut_we_i,
  input  logic [SYM_W-1:0] lut_addr_i,
  input  logic [N_ST-1:0]  lut_data_i,
  output logic [N_ST-1:0]  state_o,
  output logic             match_o,
  output logic [CNT_W-1:0] match_cnt_o
);
  import nfa_pkg::*;

  logic            rst_sync_n;
  logic            adv;
  logic            hit;
  logic [N_ST-1:0] cls_word;
  logic [N_ST-1:0] st_vec;
  logic [N_ST-1:0] eo_vec;
  logic [N_ST-1:0] clos_vec;
  logic [N_ST-1:0] set_vec;

  // Forward-only epsilon closure of the registered state vector
  function automatic logic [N_ST-1:0] eps_close(input logic [N_ST-1:0] q);
    logic [N_ST-1:0] r;
    r = q;
    for (int t = 1; t < N_ST; t++) begin
      for (int s = 0; s < t; s++) begin
        if (EPS_MAP[edge_pos(t, s, N_ST)] && r[s]) r[t] = 1'b1;
      end
    end
    return r;
  endfunction

  nfa_rst_sync u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  nfa_class_mem #(.SYM_W(SYM_W), .WORD_W(N_ST)) u_cls_mem (
    .clk_i  (clk_i),
    .we_i   (lut_we_i),
    .waddr_i(lut_addr_i),
    .wdata_i(lut_data_i),
    .raddr_i(in_byte_i),
    .rdata_o(cls_word)
  );

  assign adv      = in_valid_i & ~clr_i;
  assign clos_vec = eps_close(st_vec);

  for (genvar t = 0; t < N_ST; t++) begin : g_st
    if (t == 0) begin : g_start
      logic unused_c0;
      assign unused_c0  = cls_word[0];
      assign st_vec[0]  = 1'b1;
      assign eo_vec[0]  = 1'b1;
      assign set_vec[0] = 1'b0;
    end else begin : g_elem
      localparam logic [N_ST-1:0] LOW_MASK = N_ST'((1 << t) - 1);
      logic pred_in;
      logic eps_in;
      assign pred_in    = |(PRED_MAP[t*N_ST +: N_ST] & eo_vec);
      assign eps_in     = |(EPS_MAP[t*N_ST +: N_ST] & LOW_MASK & clos_vec);
      assign set_vec[t] = cls_word[t] & pred_in;
      nfa_match_elem u_elem (
        .clk_i (clk_i),
        .rst_ni(rst_sync_n),
        .adv_i (adv),
        .clr_i (clr_i),
        .c_i   (cls_word[t]),
        .i_i   (pred_in),
        .ei_i  (eps_in),
        .o_o   (st_vec[t]),
        .eo_o  (eo_vec[t])
      );
    end
  end

  assign hit = adv & |(set_vec & ACC_MASK);

  nfa_match_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (clr_i),
    .hit_i  (hit),
    .match_o(match_o),
    .cnt_o  (match_cnt_o)
  );

  assign state_o = st_vec;
endmodule

// File: rtl/nfa_regex_chk.sv
module nfa_regex_chk #(
  parameter int N_ST = 7,
  parameter int CNT_W = 16,
  parameter logic [N_ST-1:0] ACC_MASK = 7'b100_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             clr_i,
  input logic [N_ST-1:0]  state_o,
  input logic             match_o,
  input logic [CNT_W-1:0] match_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !clr_i) |=> $stable(state_o)); // R3

  AST_IDLE_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !match_o); // R3

  AST_MATCH_IN_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> |(state_o & ACC_MASK)); // R4

  AST_CNT_TRACKS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(match_cnt_o) == CNT_MAX) ? (match_cnt_o == CNT_MAX)
                : (match_cnt_o == $past(match_cnt_o) + CNT_W'(match_o)))); // R5

  AST_CLEAR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_o[N_ST-1:1] == '0) && !match_o && (match_cnt_o == '0)); // R6
endmodule

bind nfa_regex_top nfa_regex_chk #(.N_ST(N_ST), .CNT_W(CNT_W), .ACC_MASK(ACC_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .in_valid_i (in_valid_i),
  .clr_i      (clr_i),
  .state_o    (state_o),
  .match_o    (match_o),
  .match_cnt_o(match_cnt_o)
);

// File: tb/tb_nfa_regex_top.sv
module tb_nfa_regex_top;
  localparam int N = 7;
  localparam int CW = 3;
  localparam logic [N*N-1:0] PMAP = 49'h8082_0080_8080;
  localparam logic [N*N-1:0] EMAP = 49'h0040_0000_0000;
  localparam logic [N-1:0]   AMASK = 7'b100_0000;
  localparam logic [7:0] CH_A = 8'h61, CH_B = 8'h62, CH_C = 8'h63, CH_X = 8'h78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, clr = 1'b0, we = 1'b0;
  logic [7:0] in_byte = '0, waddr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] state;
  logic match;
  logic [CW-1:0] cnt;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit [N-1:0] m_st;
  bit         m_match;
  int         m_cnt;
  bit [N-1:0] m_lut [256];

  always #10 clk = ~clk;

  nfa_regex_top #(.N_ST(N), .SYM_W(8), .CNT_W(CW), .PRED_MAP(PMAP),
                  .EPS_MAP(EMAP), .ACC_MASK(AMASK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .clr_i(clr), .lut_we_i(we), .lut_addr_i(waddr), .lut_data_i(wdata),
    .state_o(state), .match_o(match), .match_cnt_o(cnt)
  );

  function automatic bit [N-1:0] base_cls(input logic [7:0] b);
    if (b == CH_A) return 7'b101_0010;
    if (b == CH_B) return 7'b010_0100;
    if (b == CH_C) return 7'b000_1000;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit v, input logic [7:0] b, input bit c,
                            input bit w, input logic [7:0] a, input bit [N-1:0] d);
    bit [N-1:0] reach, nxt;
    if (c) begin
      m_st = 1; m_match = 0; m_cnt = 0;
    end else if (v) begin
      reach = m_st;
      for (int t = 1; t < N; t++)
        for (int s = 0; s < t; s++)
          if (EMAP[t*N+s] && reach[s]) reach[t] = 1;
      nxt = 1;
      for (int t = 1; t < N; t++) begin
        bit any = 0;
        for (int s = 0; s < N; s++) if (PMAP[t*N+s] && reach[s]) any = 1;
        nxt[t] = m_lut[b][t] && any;
      end
      m_st = nxt;
      m_match = |(nxt & AMASK);
      if (m_match && m_cnt < 7) m_cnt++;
    end else begin
      m_match = 0;
    end
    if (w) m_lut[a] = d;
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit c, input bit w,
                      input logic [7:0] a, input bit [N-1:0] d, input string tag);
    in_valid = v; in_byte = b; clr = c; we = w; waddr = a; wdata = d;
    @(posedge clk);
    model_step(v, b, c, w, a, d);
    @(negedge clk);
    chk({tag, " state"}, 32'(state), 32'(m_st));
    chk({tag, " match"}, 32'(match), 32'(m_match));
    chk({tag, " count"}, 32'(cnt), 32'(m_cnt));
  endtask

  task automatic feed(input logic [7:0] b, input string tag);
    step(1, b, 0, 0, 8'h00, '0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_st = 1; m_match = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R8 / R1: reset values
    chk("R8 reset state", 32'(state), 32'h01);
    chk("R8 reset match", 32'(match), 32'h0);
    chk("R8 reset count", 32'(cnt), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 load lookup memory, R3 idle while loading
    for (int b = 0; b < 256; b++) step(0, 8'h00, 0, 1, 8'(b), base_cls(8'(b)), "R3 load");

    // R9 published trace
    feed(CH_A, "R9 a"); chk("R9 after a", 32'(state), 32'h03);
    feed(CH_B, "R9 b"); chk("R9 after b", 32'(state), 32'h05);
    feed(CH_C, "R9 c"); chk("R9 after c", 32'(state), 32'h09);
    feed(CH_A, "R9 a2"); chk("R9 after final a", 32'(state), 32'h53);
    chk("R4 match after abca", 32'(match), 32'h1);
    chk("R5 count one", 32'(cnt), 32'h1);
    // R2 loop through (ab)* via the epsilon edge
    feed(CH_B, "R2 loop b"); chk("R2 loop b", 32'(state), 32'h25);
    feed(CH_A, "R2 loop a"); chk("R4 loop match", 32'(match), 32'h1);

    // R3 idle
    for (int k = 0; k < 4; k++) step(0, CH_B, 0, 0, 8'h00, '0, "R3 idle");
    chk("R3 held state", 32'(state), 32'h53);

    // R6 clear beats valid
    step(1, CH_A, 1, 0, 8'h00, '0, "R6 clear");
    chk("R6 cleared state", 32'(state), 32'h01);
    chk("R6 cleared count", 32'(cnt), 32'h0);

    // R1 unanchored start
    feed(CH_X, "R1 x"); feed(CH_X, "R1 x"); feed(CH_A, "R1 a");
    feed(CH_B, "R1 b"); feed(CH_C, "R1 c"); feed(CH_A, "R1 a");
    chk("R1 late match", 32'(match), 32'h1);

    // R7 write to the byte in use reads the old word
    feed(CH_A, "R7 a"); feed(CH_B, "R7 b");
    step(1, CH_C, 0, 1, CH_C, '0, "R7 same cycle");
    chk("R7 old word used", 32'(state), 32'h09);
    feed(CH_A, "R7 a"); feed(CH_B, "R7 b"); feed(CH_C, "R7 new word");
    chk("R7 new word used", 32'(state), 32'h01);
    step(0, 8'h00, 0, 1, CH_C, base_cls(CH_C), "R7 restore");

    // any-character class on state 2
    for (int b = 0; b < 256; b++)
      step(0, 8'h00, 0, 1, 8'(b), base_cls(8'(b)) | 7'b000_0100, "R7 reload");
    step(0, 8'h00, 1, 0, 8'h00, '0, "R6 clear");
    feed(CH_A, "R2 any a"); feed(CH_X, "R2 any x"); feed(CH_C, "R2 any c"); feed(CH_A, "R2 any a");
    chk("R2 any-char match", 32'(match), 32'h1);

    // R5 saturation
    for (int k = 0; k < 10; k++) begin
      feed(CH_A, "R5 a"); feed(CH_B, "R5 b"); feed(CH_C, "R5 c"); feed(CH_A, "R5 a");
    end
    chk("R5 saturated", 32'(cnt), 32'h7);

    // mixed traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] pick [4];
      int r;
      pick[0] = CH_A; pick[1] = CH_B; pick[2] = CH_C; pick[3] = CH_X;
      r = int'($urandom_range(0, 99));
      step(r < 80, pick[$urandom_range(0, 3)], r == 99, ($urandom_range(0, 99) < 3),
           pick[$urandom_range(0, 3)], N'($urandom), "R2 mixed");
    end
    finish_run();
  end
endmodule